// File: doc/BRIEF.md
# Strobe Rising-Edge Search Engine

This block runs the per-lane delay sweep that places a sampled strobe (or a receive-enable window) on its 0-to-1 transition. It is given a starting delay for each byte lane and a mask of active lanes. It first takes three coarse samples, at the start delay and at one and two fixed steps beyond it. From the three-bit result of each lane it picks a starting offset and a search direction. It then walks each lane one delay unit at a time until every active lane sits on its edge.

Each sample is obtained through a request/acknowledge link to an external sampler, which returns one bit per lane. Before every request the block publishes the delays it wants sampled, together with a one-cycle write strobe, so that the surrounding logic can program the delay lines. When the search converges, the block raises a one-cycle precharge-all request together with its done pulse. If a delay would leave its legal range, the block stops, raises a sticky error flag and pulses done without the precharge request.

Top module: `edge_search_engine`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), dly_o is all zero and dly_wr_o, smp_req_o, prea_req_o, done_o, busy_o and err_o are all 0.
- R2: A start accepted in idle writes the coarse probe delays init, init+STEP and init+2*STEP to each active lane, in that order, with STEP = 26 by default. Every change of dly_o is flagged by dly_wr_o in the same cycle. smp_req_o is low in every write cycle and in the cycle after each acknowledged request.
- R3: The three coarse sample bits of a lane form a pattern, with the first sample in bit 2 and the last in bit 0. The pattern sets the fine start delay and direction as follows. 000 and 100 give init+2*STEP, searching forward. 001 and 101 give init+STEP, searching forward. 010 and 011 give init, searching forward. 110 and 111 give init, searching backward. The start delays are written with dly_wr_o before the first fine sample.
- R4: On each fine sample, a lane searching backward that reads 1 steps down by one unit, and a lane searching forward that reads 0 steps up by one unit. Any other lane is converged for that pass and keeps its delay.
- R5: When one fine pass finds every active lane converged, prea_req_o and done_o pulse high together for one cycle and busy_o drops. No delay write follows.
- R6: Lanes whose lane_en_i bit is 0 at start keep their dly_o value for the whole run. Their sample bits have no effect on the result.
- R7: The run ends with err_o = 1, done_o pulsed and no prea_req_o in three cases. The first is an active lane whose start delay plus 2*STEP exceeds DLY_MAX; this is detected at start and no delay is written. The second is a backward lane at delay 0 that samples 1. The third is a forward lane at delay DLY_MAX or above that samples 0. An error wins over convergence of the other lanes in the same pass.
- R8: start_i is ignored while busy_o is 1.
- R9: err_o stays 1 after an erroring run until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a search (accepted only when idle) |
| lane_en_i | input | LANES | Active-lane mask, latched at start |
| init_dly_i | input | LANES*DLY_W | Per-lane start delays, lane 0 in the low bits |
| dly_o | output | LANES*DLY_W | Per-lane delays to be programmed |
| dly_wr_o | output | 1 | One-cycle strobe: dly_o holds new values |
| smp_req_o | output | 1 | Sample request, held until acknowledged |
| smp_ack_i | input | 1 | One-cycle acknowledge carrying smp_bits_i |
| smp_bits_i | input | LANES | Sampled bit per lane |
| prea_req_o | output | 1 | One-cycle precharge-all request on success |
| done_o | output | 1 | One-cycle end-of-run pulse |
| busy_o | output | 1 | Search in progress |
| err_o | output | 1 | Sticky range error of the last run |

## Verification
Two functions can fall on the same sampler response: convergence of the last lanes and a range violation on another lane. In that case the error must win, so that err_o rises with done_o and no precharge request is issued. The bench provokes this by forcing a lane with pattern 000 to walk forward into DLY_MAX while the other lanes converge on their first fine sample. It also runs a backward walk into zero. In both runs the bench compares err_o and prea_req_o in the done cycle against a reference walk computed in the bench.

// File: rtl/edge_search_pkg.sv
// Shared types for the strobe rising-edge search engine.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package edge_search_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_CLASSIFY
    } srch_state_t;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_BWD = 1'b1
    } srch_dir_t;
endpackage

// File: rtl/edge_pattern_decode.sv
// Maps one lane's three coarse sample bits (first sample in bit 2) to the
// fine-search start delay and direction.
// Assumes: base + 2*STEP already checked against the legal range.
module edge_pattern_decode
    import edge_search_pkg::*;
#(
    parameter int DLY_W = 11,
    parameter int STEP  = 26
) (
    input  logic [2:0]       pat_i,
    input  logic [DLY_W-1:0] base_i,
    output logic [DLY_W-1:0] dly_o,
    output srch_dir_t        dir_o,
    output logic             bad_o
);
    localparam logic [DLY_W-1:0] ONE_STEP = DLY_W'(STEP);
    localparam logic [DLY_W-1:0] TWO_STEP = DLY_W'(2 * STEP);

    // Pattern table: offset in steps and direction.
    always_comb begin
        dly_o = base_i;
        dir_o = DIR_FWD;
        bad_o = 1'b0;
        case (pat_i)
            3'b000, 3'b100: dly_o = base_i + TWO_STEP;
            3'b001, 3'b101: dly_o = base_i + ONE_STEP;
            3'b010, 3'b011: dly_o = base_i;
            3'b110, 3'b111: dir_o = DIR_BWD;
            default:        bad_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/edge_lane_stepper.sv
// One fine-search step for one lane: move one unit toward the edge or
// report convergence; flags a step that would leave [0, DLY_MAX].
// Assumes: disabled lanes always report converged and never move.
module edge_lane_stepper
    import edge_search_pkg::*;
#(
    parameter int DLY_W   = 11,
    parameter int DLY_MAX = 2047
) (
    input  logic             en_i,
    input  srch_dir_t        dir_i,
    input  logic             bit_i,
    input  logic [DLY_W-1:0] cur_i,
    output logic [DLY_W-1:0] nxt_o,
    output logic             conv_o,
    output logic             err_o
);
    localparam logic [DLY_W-1:0] LIMIT = DLY_W'(DLY_MAX);

    // Next delay, convergence and range check for this pass.
    always_comb begin
        nxt_o  = cur_i;
        conv_o = 1'b1;
        err_o  = 1'b0;
        if (en_i) begin
            if (dir_i == DIR_BWD && bit_i) begin
                conv_o = 1'b0;
                if (cur_i == '0) err_o = 1'b1;
                else             nxt_o = cur_i - 1'b1;
            end else if (dir_i == DIR_FWD && !bit_i) begin
                conv_o = 1'b0;
                if (cur_i >= LIMIT) err_o = 1'b1;
                else                nxt_o = cur_i + 1'b1;
            end
        end
    end
endmodule

// File: rtl/edge_search_engine.sv
// Strobe rising-edge search: three coarse probes, pattern decode, then a
// per-lane unit walk until all active lanes converge.
// Assumes: smp_ack_i is a one-cycle pulse given only while smp_req_o is high;
// lane_en_i and init_dly_i are sampled only in the start cycle.
module edge_search_engine
    import edge_search_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int DLY_W   = 11,
    parameter int STEP    = 26,
    parameter int DLY_MAX = 2047
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic [LANES-1:0]       lane_en_i,
    input  logic [LANES*DLY_W-1:0] init_dly_i,
    output logic [LANES*DLY_W-1:0] dly_o,
    output logic                   dly_wr_o,
    output logic                   smp_req_o,
    input  logic                   smp_ack_i,
    input  logic [LANES-1:0]       smp_bits_i,
    output logic                   prea_req_o,
    output logic                   done_o,
    output logic                   busy_o,
    output logic                   err_o
);
    localparam int PW = DLY_W + 2;
    localparam logic [1:0] LAST_PROBE = 2'd2;

    srch_state_t      state_q;
    logic [1:0]       probe_q;
    logic             fine_q;
    logic [LANES-1:0] en_q;
    logic             wr_q, done_q, prea_q, err_q;
    logic [DLY_W-1:0] base_q [LANES];
    logic [DLY_W-1:0] dly_q  [LANES];
    logic [2:0]       pat_q  [LANES];
    srch_dir_t        dir_q  [LANES];

    logic [DLY_W-1:0] init_lane [LANES];
    logic [DLY_W-1:0] probe_nxt [LANES];
    logic [DLY_W-1:0] dec_dly   [LANES];
    srch_dir_t        dec_dir   [LANES];
    logic [DLY_W-1:0] step_nxt  [LANES];
    logic [LANES-1:0] rng_bad, dec_bad, step_conv, step_err;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign init_lane[l] = init_dly_i[l*DLY_W +: DLY_W];
        assign dly_o[l*DLY_W +: DLY_W] = dly_q[l];
        // Coarse range check: the farthest probe must stay legal.
        assign rng_bad[l] = lane_en_i[l] &&
            (({2'b00, init_lane[l]} + PW'(2 * STEP)) > PW'(DLY_MAX));
        // Next coarse probe delay: base + (probe+1) steps.
        assign probe_nxt[l] = base_q[l] +
            ((probe_q == 2'd0) ? DLY_W'(STEP) : DLY_W'(2 * STEP));

        edge_pattern_decode #(.DLY_W(DLY_W), .STEP(STEP)) u_dec (
            .pat_i (pat_q[l]),
            .base_i(base_q[l]),
            .dly_o (dec_dly[l]),
            .dir_o (dec_dir[l]),
            .bad_o (dec_bad[l])
        );

        edge_lane_stepper #(.DLY_W(DLY_W), .DLY_MAX(DLY_MAX)) u_step (
            .en_i  (en_q[l]),
            .dir_i (dir_q[l]),
            .bit_i (smp_bits_i[l]),
            .cur_i (dly_q[l]),
            .nxt_o (step_nxt[l]),
            .conv_o(step_conv[l]),
            .err_o (step_err[l])
        );
    end

    assign smp_req_o  = (state_q == ST_WAIT);
    assign busy_o     = (state_q != ST_IDLE);
    assign dly_wr_o   = wr_q;
    assign done_o     = done_q;
    assign prea_req_o = prea_q;
    assign err_o      = err_q;

    // Search sequencer: coarse probes, classification, fine walk, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            probe_q <= '0;
            fine_q  <= 1'b0;
            en_q    <= '0;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
            prea_q  <= 1'b0;
            err_q   <= 1'b0;
            for (int l = 0; l < LANES; l++) begin
                base_q[l] <= '0;
                dly_q[l]  <= '0;
                pat_q[l]  <= '0;
                dir_q[l]  <= DIR_FWD;
            end
        end else begin
            wr_q   <= 1'b0;
            done_q <= 1'b0;
            prea_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        err_q   <= 1'b0;
                        en_q    <= lane_en_i;
                        probe_q <= '0;
                        fine_q  <= 1'b0;
                        if (|rng_bad) begin
                            err_q  <= 1'b1;
                            done_q <= 1'b1;
                        end else begin
                            for (int l = 0; l < LANES; l++) begin
                                base_q[l] <= init_lane[l];
                                if (lane_en_i[l]) dly_q[l] <= init_lane[l];
                            end
                            wr_q    <= 1'b1;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (smp_ack_i && !fine_q) begin
                        for (int l = 0; l < LANES; l++)
                            pat_q[l][LAST_PROBE - probe_q] <= smp_bits_i[l];
                        if (probe_q == LAST_PROBE) begin
                            state_q <= ST_CLASSIFY;
                        end else begin
                            probe_q <= probe_q + 1'b1;
                            for (int l = 0; l < LANES; l++)
                                if (en_q[l]) dly_q[l] <= probe_nxt[l];
                            wr_q    <= 1'b1;
                            state_q <= ST_ISSUE;
                        end
                    end else if (smp_ack_i) begin
                        if (|step_err) begin
                            err_q   <= 1'b1;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else if (&step_conv) begin
                            prea_q  <= 1'b1;
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            dly_q   <= step_nxt;
                            wr_q    <= 1'b1;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_CLASSIFY: begin
                    if (|(dec_bad & en_q)) begin
                        err_q   <= 1'b1;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        for (int l = 0; l < LANES; l++) begin
                            if (en_q[l]) begin
                                dly_q[l] <= dec_dly[l];
                                dir_q[l] <= dec_dir[l];
                            end
                        end
                        fine_q  <= 1'b1;
                        wr_q    <= 1'b1;
                        state_q <= ST_ISSUE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/edge_search_chk.sv
// Protocol and outcome checks for the edge search engine, bound to its ports.
// Assumes: synchronous active-low reset on rst_n.
module edge_search_chk #(
    parameter int DW = 44
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] dly_o,
    input logic          dly_wr_o,
    input logic          smp_req_o,
    input logic          smp_ack_i,
    input logic          prea_req_o,
    input logic          done_o,
    input logic          busy_o,
    input logic          err_o
);
    // R2
    dly_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dly_o) |-> dly_wr_o);
    // R2
    req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_req_o && smp_ack_i) |=> !smp_req_o);
    // R2
    wr_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dly_wr_o |-> !smp_req_o);
    // R5
    prea_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prea_req_o |-> (done_o && !err_o));
    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R7
    err_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);
endmodule

bind edge_search_engine edge_search_chk #(.DW(LANES * DLY_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dly_o     (dly_o),
    .dly_wr_o  (dly_wr_o),
    .smp_req_o (smp_req_o),
    .smp_ack_i (smp_ack_i),
    .prea_req_o(prea_req_o),
    .done_o    (done_o),
    .busy_o    (busy_o),
    .err_o     (err_o)
);

// File: tb/edge_search_engine_bench.sv
module edge_search_engine_bench;
    localparam int L = 4, W = 11, MAXD = 1000, STP = 26;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst_n, start_i, dly_wr_o, smp_req_o, smp_ack_i;
    logic           prea_req_o, done_o, busy_o, err_o;
    logic [L-1:0]   lane_en_i, smp_bits_i;
    logic [L*W-1:0] init_dly_i, dly_o;

    edge_search_engine #(.LANES(L), .DLY_W(W), .STEP(STP), .DLY_MAX(MAXD))
    u_edge_search_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .lane_en_i(lane_en_i),
        .init_dly_i(init_dly_i), .dly_o(dly_o), .dly_wr_o(dly_wr_o),
        .smp_req_o(smp_req_o), .smp_ack_i(smp_ack_i), .smp_bits_i(smp_bits_i),
        .prea_req_o(prea_req_o), .done_o(done_o), .busy_o(busy_o), .err_o(err_o)
    );

    int n_chk = 0, n_fail = 0;
    int g_init [L];
    int g_ph   [L];
    logic [2:0] g_fpat [L];
    logic [L-1:0] g_en = '0;
    bit g_forced = 0;
    int nreq = 0, lat = 0, wrn = 0;
    logic [L*W-1:0] wr_log [64];

    function automatic bit fbit(int d, int ph);
        return ((d + ph) % 128) >= 64;
    endfunction

    function automatic int lane_of(logic [L*W-1:0] v, int l);
        return int'(v[l*W +: W]);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Sampler model: random latency, forced coarse patterns or periodic strobe.
    initial begin
        smp_ack_i = 0;
        smp_bits_i = '0;
        forever begin
            @(negedge clk);
            smp_ack_i = 0;
            if (smp_req_o) begin
                if (lat == 0) begin
                    for (int l = 0; l < L; l++)
                        smp_bits_i[l] = !g_en[l] ? 1'($urandom) :
                            (g_forced && nreq < 3) ? g_fpat[l][2-nreq] :
                            fbit(lane_of(dly_o, l), g_ph[l]);
                    smp_ack_i = 1;
                    nreq++;
                    lat = $urandom % 3;
                end else lat--;
            end
        end
    end

    // Delay-write log.
    always @(negedge clk)
        if (rst_n && dly_wr_o && wrn < 64) begin
            wr_log[wrn] = dly_o;
            wrn++;
        end

    // Reference search for one lane, computed from the requirements.
    task automatic ref_lane(int l, output int cls, output int fin, output bit e);
        logic [2:0] p;
        int off, d, ph;
        bit bwd;
        ph = g_ph[l];
        p = g_forced ? g_fpat[l] :
            {fbit(g_init[l], ph), fbit(g_init[l] + STP, ph), fbit(g_init[l] + 2*STP, ph)};
        bwd = 0;
        case (p)
            3'b000, 3'b100: off = 2;
            3'b001, 3'b101: off = 1;
            3'b010, 3'b011: off = 0;
            default: begin off = 0; bwd = 1; end
        endcase
        d = g_init[l] + off * STP;
        cls = d;
        e = 0;
        if (bwd) while (fbit(d, ph) && !e) begin if (d == 0) e = 1; else d--; end
        else     while (!fbit(d, ph) && !e) begin if (d >= MAXD) e = 1; else d++; end
        fin = d;
    endtask

    task automatic run(string name, bit poke);
        logic [L*W-1:0] prev;
        bit cerr, eerr, le;
        int cls [L];
        int fin [L];
        int cyc, wsave;
        prev = dly_o;
        cerr = 0;
        eerr = 0;
        for (int l = 0; l < L; l++) begin
            cls[l] = 0; fin[l] = 0;
            if (g_en[l]) begin
                if (g_init[l] + 2*STP > MAXD) cerr = 1;
                ref_lane(l, cls[l], fin[l], le);
                eerr |= le;
            end
        end
        if (cerr) eerr = 1;
        @(negedge clk);
        nreq = 0;
        wrn = 0;
        for (int l = 0; l < L; l++) init_dly_i[l*W +: W] = W'(g_init[l]);
        lane_en_i = g_en;
        start_i = 1;
        @(negedge clk);
        start_i = 0;
        if (cerr) begin
            chk(done_o && err_o && !prea_req_o, {name, " R7 coarse range stop"}, int'(err_o), 1);
            chk(wrn == 0, {name, " R7 no write on range error"}, wrn, 0);
            return;
        end
        chk(busy_o && !err_o, {name, " R9 err cleared, busy after start"}, int'(err_o), 0);
        if (poke) begin
            repeat (2) @(negedge clk);
            init_dly_i = '0;
            lane_en_i = '1;
            start_i = 1;
            @(negedge clk);
            start_i = 0;
        end
        cyc = 0;
        while (!done_o && cyc < 20000) begin @(negedge clk); cyc++; end
        chk(done_o, {name, " R5 run ended"}, int'(done_o), 1);
        chk(err_o == eerr, {name, " R7 error flag"}, int'(err_o), int'(eerr));
        chk(prea_req_o == !eerr, {name, " R5 precharge request"}, int'(prea_req_o), int'(!eerr));
        for (int l = 0; l < L; l++) begin
            if (g_en[l]) begin
                for (int k = 0; k < 3; k++)
                    chk(lane_of(wr_log[k], l) == g_init[l] + k*STP, {name, " R2 probe delay"},
                        lane_of(wr_log[k], l), g_init[l] + k*STP);
                chk(lane_of(wr_log[3], l) == cls[l], {name, " R3 classified delay"},
                    lane_of(wr_log[3], l), cls[l]);
                if (!eerr)
                    chk(lane_of(dly_o, l) == fin[l], {name, " R4 final delay"},
                        lane_of(dly_o, l), fin[l]);
            end else begin
                chk(lane_of(dly_o, l) == lane_of(prev, l), {name, " R6 inactive lane held"},
                    lane_of(dly_o, l), lane_of(prev, l));
            end
        end
        wsave = wrn;
        repeat (3) @(negedge clk);
        chk(wrn == wsave && !busy_o, {name, " R5 no write after done"}, wrn, wsave);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: search never completed (R5)");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7319));
        rst_n = 0; start_i = 0; lane_en_i = '0; init_dly_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(dly_o == '0 && !dly_wr_o && !smp_req_o && !prea_req_o && !done_o && !busy_o && !err_o,
            "R1 reset state", int'(busy_o), 0);

        // R3 forced patterns 000..011 then 100..111
        g_en = '1;
        g_forced = 1;
        for (int l = 0; l < L; l++) begin
            g_init[l] = 300 + 20*l; g_ph[l] = $urandom % 128; g_fpat[l] = 3'(l);
        end
        run("forced A", 0);
        for (int l = 0; l < L; l++) begin
            g_ph[l] = $urandom % 128; g_fpat[l] = 3'(l + 4);
        end
        run("forced B", 0);

        // R7 coarse range error, then R9 sticky flag
        g_forced = 0;
        g_en = 4'b0011;
        g_init[0] = 100; g_init[1] = 960;
        run("coarse range", 0);
        repeat (5) @(negedge clk);
        chk(err_o, "R9 error flag sticky", int'(err_o), 1);

        // R7 forward overflow on the pass where other lanes converge
        g_en = '1;
        g_forced = 1;
        for (int l = 1; l < L; l++) begin g_init[l] = 100; g_ph[l] = 0; g_fpat[l] = 3'b011; end
        g_init[0] = 940; g_ph[0] = 32; g_fpat[0] = 3'b000;
        run("forward limit", 0);

        // R7 backward underflow
        g_init[0] = 10; g_ph[0] = 64; g_fpat[0] = 3'b111;
        run("backward zero", 0);

        // R6 inactive lanes, R8 start while busy
        g_forced = 0;
        g_en = 4'b0101;
        for (int l = 0; l < L; l++) begin g_init[l] = 200 + 50*l; g_ph[l] = $urandom % 128; end
        run("inactive lanes", 0);
        g_en = '1;
        run("R8 start while busy", 1);

        // Random runs
        for (int r = 0; r < 30; r++) begin
            g_en = 4'($urandom % 15 + 1);
            for (int l = 0; l < L; l++) begin
                g_init[l] = $urandom % 900; g_ph[l] = $urandom % 128;
            end
            run("random", 0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule